// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a stage register that turns a parallel word into a serial bit stream, or takes in serial data one bit per clock. Only the final stage is visible at the output. A shift/load select picks the operation for each clock edge. An inhibit input pauses the register while the system clock keeps running. An active-low clear empties every stage at once, without waiting for a clock edge.

A typical user loads a word with the select low and then raises the select. Each following edge moves the word one stage toward the output, with the last word bit appearing first. Inhibit is used to stall the stream for any number of cycles. The clear is asserted asynchronously. Its release is synchronised to the clock, so the first edge after the clear rises only arms the register.

Top module: `gated_pload_shifter`

## Requirements
- R1: While `clrN` is low, every stage is zero and `lastQ` reads 0 at once, before any clock edge and regardless of every other input.
- R2: The first rising edge after `clrN` returns high changes no stage. The selected operation takes effect from the second edge onward.
- R3: On a rising edge with `inhibit` low and `shiftSel` low, stage i takes `parIn[i]`. Index 0 is the stage nearest the serial input and index WIDTH-1 drives `lastQ`, so `lastQ` then equals `parIn[WIDTH-1]`.
- R4: On a rising edge with `inhibit` low and `shiftSel` high, stage 0 takes `serIn` and stage i takes the old stage i-1. After a load, `lastQ` therefore shows `parIn[WIDTH-1]`, `parIn[WIDTH-2]`, ... on successive shift edges, and each serial bit reaches `lastQ` WIDTH shift edges after it enters.
- R5: On a rising edge with `inhibit` high, every stage holds its value, whatever `shiftSel`, `serIn` and `parIn` are.
- R6: During a load edge, `serIn` has no effect on any stage.
- R7: The stage count is the parameter WIDTH (default 8), and only the last stage is brought out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; the register acts on the rising edge |
| clrN | input | 1 | Active-low clear; asserts asynchronously, releases synchronously |
| inhibit | input | 1 | High holds all stages on the coming edge |
| shiftSel | input | 1 | 1 selects serial shift, 0 selects parallel load |
| serIn | input | 1 | Serial data into stage 0 |
| parIn | input | WIDTH | Parallel word; bit i goes to stage i |
| lastQ | output | 1 | Content of the final stage |

## Verification
The assertions assume that `inhibit`, `shiftSel`, `serIn` and `parIn` are stable around each rising edge. They also assume that `inhibit` is raised only while the clock is high, so that gating never creates a spurious edge. The stimulus meets both assumptions by changing every input, `clrN` included, two nanoseconds after a rising edge, while the clock is still high. The sweep loads every 8-bit word and then shifts it with inhibit stalls mixed in. It ends with a clear applied between edges in the middle of a word.

// File: rtl/plsr_pkg.sv
package plsr_pkg;
  // Per-edge command from the control to the stage datapath.
  typedef struct packed {
    logic load;
    logic shift;
  } stageCmd_t;
endpackage

// File: rtl/plsr_ctrl.sv
module plsr_ctrl
  import plsr_pkg::*;
(
  input  logic      clk,
  input  logic      clrN,
  input  logic      inhibit,
  input  logic      shiftSel,
  output stageCmd_t cmd
);

  // Release of the clear is retimed: the register only acts once armed.
  logic armed;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic advance;
  assign advance   = armed && !inhibit;
  assign cmd.load  = advance && !shiftSel;
  assign cmd.shift = advance && shiftSel;

  // R3: load and shift never requested on the same edge
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!clrN)
    $onehot0({cmd.load, cmd.shift}));

  // R2: edge right after clear release issues no command
  p_release_idle_r2: assert property (@(posedge clk) disable iff (!clrN)
    !$past(clrN) |-> (cmd == '0));

  // R5: inhibit suppresses every command
  p_inhibit_quiet_r5: assert property (@(posedge clk) disable iff (!clrN)
    inhibit |-> !cmd.load && !cmd.shift);

endmodule

// File: rtl/plsr_stages.sv
module plsr_stages
  import plsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clrN,
  input  stageCmd_t        cmd,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] feedIn;

  // Each stage picks its parallel bit on load, its upstream neighbour on shift.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic upstream;
    if (i == 0) begin : g_head
      assign upstream = serIn;
    end else begin : g_body
      assign upstream = stageQ[i-1];
    end
    assign feedIn[i] = cmd.load ? parIn[i] : upstream;

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN)                       stageQ[i] <= 1'b0;
      else if (cmd.load || cmd.shift)  stageQ[i] <= feedIn[i];
    end
  end

  // R3, R6: a load edge copies the parallel word, serial input unused
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!clrN)
    cmd.load |=> stageQ == $past(parIn));

  // R4: a shift edge moves every stage up by one
  p_shift_move_r4: assert property (@(posedge clk) disable iff (!clrN)
    cmd.shift |=> stageQ == {$past(stageQ[LAST-1:0]), $past(serIn)});

  // R5: no command, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!clrN)
    !cmd.load && !cmd.shift |=> $stable(stageQ));

endmodule

// File: rtl/gated_pload_shifter.sv
module gated_pload_shifter
  import plsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             inhibit,
  input  logic             shiftSel,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             lastQ
);

  stageCmd_t        cmd;
  logic [WIDTH-1:0] stageQ;

  plsr_ctrl u_ctrl (
    .clk      (clk),
    .clrN     (clrN),
    .inhibit  (inhibit),
    .shiftSel (shiftSel),
    .cmd      (cmd)
  );

  plsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk    (clk),
    .clrN   (clrN),
    .cmd    (cmd),
    .serIn  (serIn),
    .parIn  (parIn),
    .stageQ (stageQ)
  );

  // R7: only the final stage leaves the block
  assign lastQ = stageQ[WIDTH-1];

endmodule

// File: tb/gated_pload_shifter_tb.sv
module gated_pload_shifter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clrN = 1'b0;
  logic         inhibit = 1'b0;
  logic         shiftSel = 1'b0;
  logic         serIn = 1'b0;
  logic [W-1:0] parIn = '0;
  logic         lastQ;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] refQ = '0;
  logic         refArmed = 1'b0;

  always #4 clk = ~clk;

  gated_pload_shifter #(.WIDTH(W)) u_dut (
    .clk(clk), .clrN(clrN), .inhibit(inhibit), .shiftSel(shiftSel),
    .serIn(serIn), .parIn(parIn), .lastQ(lastQ)
  );

  task automatic check(input string req, input logic exp);
    tests++;
    if (lastQ !== exp) begin
      fails++;
      $display("FAIL %s at %0t: lastQ=%b expected=%b", req, $time, lastQ, exp);
    end
  endtask

  // Called 2 ns after a rising edge (clock high): drive, then run one edge.
  task automatic step(input logic c, input logic inh, input logic sh,
                      input logic ser, input logic [W-1:0] par, input string req);
    clrN = c; inhibit = inh; shiftSel = sh; serIn = ser; parIn = par;
    if (!c) begin
      refQ = '0; refArmed = 1'b0;
      #1 check("R1 async", 1'b0);
    end
    @(posedge clk);
    #1;
    if (clrN) begin
      if (!refArmed)        refArmed = 1'b1;
      else if (!inhibit) begin
        if (shiftSel) refQ = {refQ[W-2:0], serIn};
        else          refQ = parIn;
      end
    end
    check(req, refQ[W-1]);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, "R1 reset");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, "R1 reset");
    // Release: first edge must not load the all-ones word.
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R2 release");
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R3 first load");
    // Sweep every word, shifting it out with stalls mixed in.
    for (int b = 0; b < 256; b++) begin
      logic [W-1:0] w;
      w = b[W-1:0];
      step(1'b1, 1'b0, 1'b0, ~w[0], w, "R3/R6 load");
      for (int k = 0; k < W; k++) begin
        logic inh;
        inh = ((b + k) % 5) == 0;
        step(1'b1, inh, inh ? w[k] : 1'b1, w[k] ^ w[(k+3)%W], ~w,
             inh ? "R5 hold" : "R4 shift");
      end
    end
    // Serial-only traffic: pattern reaches lastQ WIDTH shifts later.
    for (int k = 0; k < 3 * W; k++)
      step(1'b1, 1'b0, 1'b1, (k % 3) == 1, 8'h00, "R4 serial");
    // Clear in the middle of a word, between edges, then held over an edge.
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R3 reload");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, "R1 mid-word");
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R2 second release");
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R4 after release");
    for (int k = 0; k < W; k++)
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R7 serial to last stage");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule